// File: doc/BRIEF.md
# Write-Only Two-Wire Configuration Slave

This block is the serial front end of a small configuration device on a two-wire bus. It watches SCL and SDA through synchronizers running on the system clock and finds START and STOP conditions. Between them it collects an address byte, a command byte and data bytes. It never sends data. Its only output onto the bus is a pull-low enable for the open-drain SDA pad, which it raises during acknowledge slots.

The device address has seven bits. The upper four are fixed at 0101. The next two come from a build-time parameter, and the lowest comes from a strap pin. The eighth bit of the address byte selects either a write or a harmless no-operation. A write frame hands each received data byte, together with the command byte that selected its target, to a register controller through a one-cycle strobe.

Top module: `i2cw_slave`

## Requirements
- R1: After reset, `sda_pull` and `wr_stb` are low, and the block waits for a START.
- R2: The address byte is taken MSB first. Its upper seven bits must equal {0101, `DEV_BITS`, `addr_strap`}, with `DEV_BITS` defaulting to 2'b00. When they match and bit 0 is 0 (write), the slave raises `sda_pull` from the eighth SCL falling edge until the ninth SCL falling edge, so SDA stays low for the whole ninth high phase.
- R3: When the address does not match, the slave gives no acknowledge. It drives no pull and issues no strobe for any byte until the next START.
- R4: When the address matches with bit 0 set to 1 (no-op), the address is acknowledged. Any bytes that follow in that frame are neither acknowledged nor strobed.
- R5: In a write frame, the byte after the address is the command. It is acknowledged and shown on `cmd_o`. The next byte is acknowledged and shown on `data_o`, and `wr_stb` goes high for exactly one clock at the SCL falling edge that ends its eighth bit.
- R6: Each further data byte before a STOP or START is acknowledged and strobed again, with the same command.
- R7: A START or STOP at any bit position ends the current frame, drops any partial byte and releases `sda_pull` on the next clock. A repeated START begins a new address byte. After a STOP, bytes are ignored until a START.
- R8: `sda_pull` is never raised during the eight data bits of a byte, so the slave never disturbs data sent by the master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| addr_strap | input | 1 | Strap pin that sets address bit 0 |
| sda_pull | output | 1 | Enable for the open-drain pull-low on SDA |
| cmd_o | output | 8 | Command byte of the current write frame |
| data_o | output | 8 | Most recent data byte |
| wr_stb | output | 1 | One-cycle strobe: `cmd_o` and `data_o` are valid |

## Verification
On every cycle, the assertions check how the pull and the strobe are timed against the synchronized bus events. The pull may rise only on an SCL falling edge, and it may fall only on a falling edge or a bus condition. START and STOP clear it. The strobe lasts one clock and lines up with a falling edge. Whether a given byte should be acknowledged, and what reaches the controller, depend on the address, the no-op flag and where aborts fall. Only the bench scenarios show that: matching and mismatching addresses, both strap values, no-op frames, multi-byte writes, and frames cut off mid-byte by a repeated START or a STOP.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int BYTE_W = 8;
  localparam int ADR_W  = 7;
  localparam logic [3:0] ADR_TOP = 4'b0101;

  typedef enum logic [2:0] {
    FR_IDLE, FR_ADDR, FR_CMD, FR_DATA, FR_SKIP
  } frame_e;

  function automatic logic [ADR_W-1:0] own_addr(input logic [1:0] dev_bits,
                                                input logic strap);
    return {ADR_TOP, dev_bits, strap};
  endfunction

  function automatic logic addr_hit(input logic [ADR_W-1:0] rx,
                                    input logic [1:0] dev_bits,
                                    input logic strap);
    return rx == own_addr(dev_bits, strap);
  endfunction
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/i2cw_shifter.sv
module i2cw_shifter
  import i2cw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              ack_en,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_done,
  output logic              sda_pull
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  logic [CNT_W-1:0] cnt;
  logic             ack_ph;

  assign byte_done = scl_fall && (cnt == FULL) && !ack_ph && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      ack_ph   <= 1'b0;
      sda_pull <= 1'b0;
      rx_byte  <= '0;
    end else if (clear) begin
      cnt      <= '0;
      ack_ph   <= 1'b0;
      sda_pull <= 1'b0;
    end else if (scl_fall && ack_ph) begin
      cnt      <= '0;
      ack_ph   <= 1'b0;
      sda_pull <= 1'b0;
    end else if (byte_done) begin
      ack_ph   <= 1'b1;
      sda_pull <= ack_en;
    end else if (scl_rise && (cnt < FULL) && !ack_ph) begin
      rx_byte <= {rx_byte[BYTE_W-2:0], sda_lvl};
      cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2cw_frame.sv
module i2cw_frame
  import i2cw_pkg::*;
#(
  parameter logic [1:0] DEV_BITS = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              addr_strap,
  output logic              ack_en,
  output logic [BYTE_W-1:0] cmd_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              wr_stb
);
  frame_e st;
  logic   hit;

  assign hit = addr_hit(rx_byte[BYTE_W-1:1], DEV_BITS, addr_strap);

  always_comb begin
    case (st)
      FR_ADDR: ack_en = hit;
      FR_CMD,
      FR_DATA: ack_en = 1'b1;
      default: ack_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= FR_IDLE;
      cmd_o  <= '0;
      data_o <= '0;
      wr_stb <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (start_ev) begin
        st <= FR_ADDR;
      end else if (stop_ev) begin
        st <= FR_IDLE;
      end else if (byte_done) begin
        case (st)
          FR_ADDR: st <= !hit ? FR_IDLE : (rx_byte[0] ? FR_SKIP : FR_CMD);
          FR_CMD: begin
            cmd_o <= rx_byte;
            st    <= FR_DATA;
          end
          FR_DATA: begin
            data_o <= rx_byte;
            wr_stb <= 1'b1;
          end
          default: st <= st;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cw_slave.sv
module i2cw_slave
  import i2cw_pkg::*;
#(
  parameter logic [1:0] DEV_BITS    = 2'b00,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_strap,
  output logic              sda_pull,
  output logic [BYTE_W-1:0] cmd_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              wr_stb
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic start_ev, stop_ev, byte_done, ack_en;
  logic [BYTE_W-1:0] rx_byte;

  i2cw_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst_n(rst_n), .din(scl_i),
    .lvl(scl_lvl), .rise(scl_rise), .fall(scl_fall));

  i2cw_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst_n(rst_n), .din(sda_i),
    .lvl(sda_lvl), .rise(sda_rise), .fall(sda_fall));

  assign start_ev = scl_lvl & sda_fall;
  assign stop_ev  = scl_lvl & sda_rise;

  i2cw_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .clear(start_ev | stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
    .ack_en(ack_en), .rx_byte(rx_byte), .byte_done(byte_done),
    .sda_pull(sda_pull));

  i2cw_frame #(.DEV_BITS(DEV_BITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .stop_ev(stop_ev),
    .byte_done(byte_done), .rx_byte(rx_byte), .addr_strap(addr_strap),
    .ack_en(ack_en), .cmd_o(cmd_o), .data_o(data_o), .wr_stb(wr_stb));
endmodule

// File: rtl/i2cw_slave_chk.sv
module i2cw_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_fall,
  input logic start_ev,
  input logic stop_ev,
  input logic sda_pull,
  input logic wr_stb
);
  // R2
  pull_rise_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(scl_fall));

  // R8
  pull_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> $past(scl_fall | start_ev | stop_ev));

  // R7
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev | stop_ev) |=> !sda_pull);

  // R5
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R5
  stb_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(scl_fall));
endmodule

bind i2cw_slave i2cw_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_ev(start_ev),
  .stop_ev(stop_ev), .sda_pull(sda_pull), .wr_stb(wr_stb));

// File: tb/i2cw_slave_test.sv
module i2cw_slave_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic strap = 1'b0;
  logic sda_pull, wr_stb;
  logic [7:0] cmd_o, data_o;
  wire  sda_bus = sda_m & ~sda_pull;

  int checks = 0;
  int errors = 0;
  int stb_seen = 0;
  int stb_exp = 0;
  logic [15:0] sb_q[$];

  localparam int H = 20;
  localparam int Q = 5;

  always #2.5 clk = ~clk;

  i2cw_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_strap(strap), .sda_pull(sda_pull), .cmd_o(cmd_o),
    .data_o(data_o), .wr_stb(wr_stb));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      stb_seen++;
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R3/R4/R7 actual=%0h expected=none", {cmd_o, data_o});
      end else begin
        logic [15:0] e;
        e = sb_q.pop_front();
        if ({cmd_o, data_o} !== e) begin
          errors++;
          $display("FAIL R5/R6 actual=%0h expected=%0h", {cmd_o, data_o}, e);
        end
      end
    end
  end

  task automatic push(input logic [7:0] c, input logic [7:0] d);
    sb_q.push_back({c, d});
    stb_exp++;
  endtask

  task automatic go_start();
    sda_m = 1'b0; wt(H); scl_m = 1'b0;
  endtask

  task automatic go_restart();
    wt(Q); sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b0;
  endtask

  task automatic go_stop();
    wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(H);
  endtask

  task automatic send_bit(input logic b, output logic seen);
    wt(Q); sda_m = b; wt(Q); scl_m = 1'b1; wt(H / 2); seen = sda_bus; wt(H / 2); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, input bit exp_ack, input string req);
    logic seen;
    bit   clean = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      send_bit(v[i], seen);
      if (seen !== v[i]) clean = 1'b0;
    end
    chk(clean, "R8", 0, 1);
    send_bit(1'b1, seen);
    chk((!seen) == exp_ack, req, !seen, exp_ack);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic dummy;
    wt(4);
    // R1 reset state
    chk(sda_pull == 1'b0, "R1", sda_pull, 0);
    chk(wr_stb == 1'b0, "R1", wr_stb, 0);
    rst_n = 1'b1;
    wt(10);
    chk(sda_pull == 1'b0 && wr_stb == 1'b0, "R1", {sda_pull, wr_stb}, 0);

    // R2 / R5 basic write, strap low -> address 0101000
    go_start();
    send_byte(8'h50, 1, "R2");
    send_byte(8'h12, 1, "R5");
    push(8'h12, 8'hA5);
    send_byte(8'hA5, 1, "R5");
    go_stop();
    chk(stb_seen == stb_exp, "R5", stb_seen, stb_exp);
    chk(sda_pull == 1'b0, "R7", sda_pull, 0);

    // R3 strap bit mismatch
    go_start();
    send_byte(8'h52, 0, "R3");
    send_byte(8'h12, 0, "R3");
    send_byte(8'h33, 0, "R3");
    go_stop();
    // R3 upper nibble mismatch
    go_start();
    send_byte(8'h70, 0, "R3");
    send_byte(8'h44, 0, "R3");
    go_stop();
    chk(stb_seen == stb_exp, "R3", stb_seen, stb_exp);

    // R4 no-op flag
    go_start();
    send_byte(8'h51, 1, "R4");
    send_byte(8'h05, 0, "R4");
    send_byte(8'h77, 0, "R4");
    go_stop();
    chk(stb_seen == stb_exp, "R4", stb_seen, stb_exp);

    // R6 multiple data bytes share the command
    go_start();
    send_byte(8'h50, 1, "R2");
    send_byte(8'h40, 1, "R5");
    push(8'h40, 8'h01);
    send_byte(8'h01, 1, "R6");
    push(8'h40, 8'h02);
    send_byte(8'h02, 1, "R6");
    push(8'h40, 8'hFE);
    send_byte(8'hFE, 1, "R6");
    go_stop();
    chk(stb_seen == stb_exp, "R6", stb_seen, stb_exp);

    // R2 strap high -> address 0101001
    strap = 1'b1;
    wt(10);
    go_start();
    send_byte(8'h50, 0, "R2");
    go_restart();
    send_byte(8'h52, 1, "R2");
    send_byte(8'h09, 1, "R5");
    push(8'h09, 8'h3C);
    send_byte(8'h3C, 1, "R5");
    go_stop();
    chk(stb_seen == stb_exp, "R2", stb_seen, stb_exp);

    // R7 repeated START after a partial data byte
    go_start();
    send_byte(8'h52, 1, "R2");
    send_byte(8'h07, 1, "R5");
    send_bit(1'b1, dummy);
    send_bit(1'b0, dummy);
    send_bit(1'b1, dummy);
    go_restart();
    send_byte(8'h52, 1, "R7");
    send_byte(8'h08, 1, "R7");
    push(8'h08, 8'h99);
    send_byte(8'h99, 1, "R7");
    go_stop();
    chk(stb_seen == stb_exp, "R7", stb_seen, stb_exp);

    // R7 STOP after the command byte, then bytes with no START
    go_start();
    send_byte(8'h52, 1, "R2");
    send_byte(8'h0A, 1, "R5");
    go_stop();
    scl_m = 1'b0;
    send_byte(8'h55, 0, "R7");
    send_byte(8'hC3, 0, "R7");
    go_stop();
    chk(stb_seen == stb_exp, "R7", stb_seen, stb_exp);
    chk(sb_q.size() == 0, "R6", sb_q.size(), 0);

    wt(20);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule